// File: doc/BRIEF.md
# Four-Stage Shared-Unit Pixel Arithmetic Pipeline

This block evaluates a per-pixel expression over six signed operands k, l, m, n, o and p. It forms x1 = k*l - (l - m), then x2 = x1 + n, then x3 = x2 * o, and finally x4 = x3 + p, and it presents x4 as its only data output. Only three arithmetic units exist: one multiplier, one adder and one subtractor. Each unit has a two-way operand multiplexer and serves two different steps of the expression.

Work is organised in windows of two clock cycles. A new operand set enters every window, and up to four sets are in flight at once. A phase bit selects the operands of each unit. In the first cycle of a window the multiplier forms k*l. In the second cycle it forms x2*o. The operands n, o and p are consumed late, so they travel through register chains of one, two and three stages. These chains shift once per window.

The enable input `root` freezes the whole block when low, including the phase. A synchronous reset clears the controller and every data register.

Top module: `pix_pipe4`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `x4` = 0 and `step` = 0. Every internal data register is also cleared, so the next three windows show `x4` = 0.
- R2: `step` inverts at each rising edge where `root` is high. A window is the `step`=0 cycle plus the following `step`=1 cycle. The operand inputs k, l, m, n, o and p are held constant over both cycles of their window.
- R3: `x4` equals x3 + p, where x1 = k*l - (l - m), x2 = x1 + n and x3 = x2 * o. All operands and intermediates are signed and W bits wide (W=16 by default).
- R4: The set supplied in window w appears on `x4` from the edge that ends the `step`=0 cycle of window w+3. It stays until the same edge of window w+4.
- R5: `x4` changes only at an edge that ends a `step`=0 cycle with `root` high.
- R6: At an edge where `root` is low, no state changes: `x4` and `step` are held. Results continue in order once `root` returns, counting only active windows.
- R7: Every product, sum and difference wraps modulo 2^W, with the low W bits kept. This includes products of full-scale operands.
- R8: A new operand set is accepted in every window. Consecutive sets do not disturb each other, including their delayed n, o and p values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| root | input | 1 | Enable; low stalls the pipeline |
| k | input | W | Operand of the first product |
| l | input | W | Operand of the first product and of the difference |
| m | input | W | Subtrahend of the difference |
| n | input | W | Addend for x2 |
| o | input | W | Multiplier operand for x3 |
| p | input | W | Addend for x4 |
| step | output | 1 | Window phase; 0 in the first cycle of a window |
| x4 | output | W | Result of the expression |

## Verification
A phase bit that slips off its alternation makes a shared unit take the wrong operand pair. `x4` then goes wrong within three windows of the slip, and `step` breaks its toggling at once. A delay chain with a missing or extra stage pairs n, o or p with a neighbouring set. Because consecutive sets differ, this shows up as a mismatch in the first window that sampled the bad chain, three windows after the set entered. Stall cycles are spread through the run, so any register that moves while `root` is low shows as a change of `x4` or `step` across the stall. A skewed pipeline register also shifts every later result by one window.

// File: rtl/pix_pipe4.sv
module pix_pipe4 #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                root,
  input  logic signed [W-1:0] k,
  input  logic signed [W-1:0] l,
  input  logic signed [W-1:0] m,
  input  logic signed [W-1:0] n,
  input  logic signed [W-1:0] o,
  input  logic signed [W-1:0] p,
  output logic                step,
  output logic signed [W-1:0] x4
);

  logic signed [W-1:0]   r_kl, r_lm, r_x1, r_x2, r_x3;
  logic signed [W-1:0]   n_d1;
  logic signed [W-1:0]   o_d0, o_d1;
  logic signed [W-1:0]   p_d0, p_d1, p_d2;
  logic signed [W-1:0]   mul_a, mul_b, add_a, add_b, sub_a, sub_b;
  logic signed [W-1:0]   mul_y, add_y, sub_y;
  logic signed [2*W-1:0] prod;

  assign mul_a = step ? r_x2 : k;
  assign mul_b = step ? o_d1 : l;
  assign add_a = step ? r_x1 : r_x3;
  assign add_b = step ? n_d1 : p_d2;
  assign sub_a = step ? l    : r_kl;
  assign sub_b = step ? m    : r_lm;

  assign prod  = mul_a * mul_b;
  assign mul_y = prod[W-1:0];
  assign add_y = add_a + add_b;
  assign sub_y = sub_a - sub_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= 1'b0;
      x4   <= '0;
      r_kl <= '0;
      r_lm <= '0;
      r_x1 <= '0;
      r_x2 <= '0;
      r_x3 <= '0;
      n_d1 <= '0;
      o_d0 <= '0;
      o_d1 <= '0;
      p_d0 <= '0;
      p_d1 <= '0;
      p_d2 <= '0;
    end else if (root) begin
      step <= ~step;
      if (!step) begin
        r_kl <= mul_y;
        r_x1 <= sub_y;
        x4   <= add_y;
      end else begin
        r_lm <= sub_y;
        r_x2 <= add_y;
        r_x3 <= mul_y;
        n_d1 <= n;
        o_d0 <= o;
        o_d1 <= o_d0;
        p_d0 <= p;
        p_d1 <= p_d0;
        p_d2 <= p_d1;
      end
    end
  end

endmodule

// File: rtl/pix_pipe4_chk.sv
module pix_pipe4_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                root,
  input logic                step,
  input logic signed [W-1:0] x4,
  input logic signed [W-1:0] n,
  input logic signed [W-1:0] n_d1,
  input logic signed [W-1:0] o_d0,
  input logic signed [W-1:0] o_d1
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (x4 == '0 && !step));

  assert_step_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    root |=> (step != $past(step)));

  assert_update_slot_R5: assert property (@(posedge clk) disable iff (rst)
    (root && step) |=> $stable(x4));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !root |=> ($stable(x4) && $stable(step)));

  assert_n_chain_R8: assert property (@(posedge clk) disable iff (rst)
    (root && step) |=> (n_d1 == $past(n)));

  assert_o_chain_R8: assert property (@(posedge clk) disable iff (rst)
    (root && step) |=> (o_d1 == $past(o_d0)));

endmodule

bind pix_pipe4 pix_pipe4_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .root(root), .step(step), .x4(x4),
  .n(n), .n_d1(n_d1), .o_d0(o_d0), .o_d1(o_d1)
);

// File: tb/tb_pix_pipe4.sv
`timescale 1ns/1ps
module tb_pix_pipe4;
  localparam int W = 16;
  localparam int NWIN = 400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic root = 1'b0;
  logic signed [W-1:0] k = '0, l = '0, m = '0, n = '0, o = '0, p = '0;
  logic step;
  logic signed [W-1:0] x4;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic signed [W-1:0] expq [NWIN];

  always #10 clk = ~clk;

  pix_pipe4 #(.W(W)) dut (
    .clk(clk), .rst(rst), .root(root), .k(k), .l(l), .m(m), .n(n), .o(o), .p(p),
    .step(step), .x4(x4)
  );

  function automatic logic signed [W-1:0] ref_val(
    input logic signed [W-1:0] ak, al, am, an, ao, ap);
    logic signed [W-1:0] t1, t2, t3, t4, kl, lm;
    kl = ak * al;
    lm = al - am;
    t1 = kl - lm;
    t2 = t1 + an;
    t3 = t2 * ao;
    t4 = t3 + ap;
    return t4;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic stall(input int cyc);
    logic signed [W-1:0] hx;
    logic hs;
    hx = x4;
    hs = step;
    root = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
    check("R6 x4 held during stall", x4, hx);
    check("R6 step held during stall", {{(W-1){1'b0}}, step}, {{(W-1){1'b0}}, hs});
    root = 1'b1;
  endtask

  initial begin
    logic signed [W-1:0] prev;
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 x4 after reset", x4, '0);
    check("R1 step after reset", {{(W-1){1'b0}}, step}, '0);
    rst = 1'b0;
    root = 1'b1;
    prev = x4;
    for (int w = 0; w < NWIN; w++) begin
      case (w)
        5:  begin k = 16'sh7fff; l = 16'sh7fff; m = 16'sh8000; n = 16'sh7fff; o = 16'sh7fff; p = 16'sh7fff; end
        6:  begin k = 16'sh8000; l = 16'sh8000; m = 16'sh7fff; n = 16'sh8000; o = 16'sh8000; p = 16'sh8000; end
        7:  begin k = '0; l = '0; m = '0; n = '0; o = '0; p = '0; end
        8:  begin k = 16'sd3; l = 16'sd4; m = 16'sd1; n = 16'sd2; o = 16'sd5; p = 16'sd7; end
        9:  begin k = -16'sd1; l = -16'sd1; m = -16'sd1; n = -16'sd1; o = -16'sd1; p = -16'sd1; end
        default: begin
          k = W'($urandom); l = W'($urandom); m = W'($urandom);
          n = W'($urandom); o = W'($urandom); p = W'($urandom);
        end
      endcase
      expq[w] = ref_val(k, l, m, n, o, p);
      check("R2 step low at window start", {{(W-1){1'b0}}, step}, '0);
      check("R5 x4 steady through second cycle", x4, prev);
      @(posedge clk);
      @(negedge clk);
      if (w % 7 == 3) stall(1 + (w % 3));
      if (w < 3)
        check("R1 zero-filled pipeline", x4, '0);
      else if (w >= 8 && w <= 12)
        check("R7 wraparound corner", x4, expq[w-3]);
      else
        check("R4 R3 R8 result latency", x4, expq[w-3]);
      check("R2 step high in second cycle", {{(W-1){1'b0}}, step}, {{(W-1){1'b0}}, 1'b1});
      prev = x4;
      if (w % 11 == 5) stall(2);
      @(posedge clk);
      @(negedge clk);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule